// File: doc/BRIEF.md
# I2C Bus Fault Guard

This block watches the two lines of an I2C bus while a byte or acknowledge bit is being clocked and raises a bus fault when a START or STOP condition shows up in the middle of that frame. It is meant to sit beside a byte engine. The byte engine reports when a frame is in flight and whether the controller currently owns the link, as master or as an addressed slave. When a fault is detected, the block raises the serial interrupt flag and presents the fault status code.

Software recovers the bus by setting the stop-request flag and clearing the interrupt flag, in either order. When both are done, the block emits single-cycle strobes. These strobes tell the line drivers to let go of SDA and SCL and tell the mode logic to drop to the unaddressed slave state. At the same time the block clears the stop-request flag by itself. It never produces a STOP condition on the bus. A START or STOP seen between frames, or while the controller does not own the link, is ordinary bus traffic and is ignored.

Top module: `i2c_fault_guard`

## Requirements
- R1: A START (synchronized SDA falling while SCL stays high) seen while `byte_active` and `link_owned` are both 1 sets `si` to 1 and makes `status` read 0x00.
- R2: A STOP (synchronized SDA rising while SCL stays high) under the same conditions sets `si` to 1 and makes `status` read 0x00.
- R3: A START or STOP while `link_owned` is 0 leaves `si` at 0.
- R4: A START or STOP while `byte_active` is 0 leaves `si` at 0.
- R5: Whenever `si` is 0, including after reset, `status` reads 0xF8.
- R6: An SDA change while SCL is low during a frame is a data bit and never raises a fault.
- R7: While a fault is pending, the first cycle in which `sto` is 1 and `si` is 0 produces exactly one cycle of `sda_release`, `scl_release` and `drop_to_unaddressed`, and clears `sto` on that same edge.
- R8: Setting only `sto`, or clearing only `si`, during a pending fault produces no release strobe. Further conditions on the bus while the fault is pending do not set `si` again.
- R9: `sto_set` outside a pending fault sets `sto`, and `sto` stays 1 with no strobe until a fault is recovered. Pulsing `si_clear` leaves `sto` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| byte_active | input | 1 | High from the first SCL edge of a byte through its acknowledge clock |
| link_owned | input | 1 | High in master mode or addressed slave mode |
| sto_set | input | 1 | CPU write pulse setting the stop-request flag |
| si_clear | input | 1 | CPU write pulse clearing the interrupt flag |
| sto | output | 1 | Stop-request flag |
| si | output | 1 | Serial interrupt flag |
| status | output | 8 | Status code |
| sda_release | output | 1 | One-cycle strobe freeing SDA |
| scl_release | output | 1 | One-cycle strobe freeing SCL |
| drop_to_unaddressed | output | 1 | One-cycle strobe forcing the unaddressed slave state |

## Verification
The hardest situation to reach is a pending fault whose recovery handshake is only half done while further bus conditions keep arriving. If the bench got this wrong, the guard could re-flag the fault or release the lines early. The directed part of the bench builds a fault, sets only `sto` or clears only `si`, then injects more STARTs and checks that no strobe appears. Random frames drawn from a fixed seed then mix ownership, frame position and condition type, and each fault is recovered, with the strobes counted at the ports.

// File: rtl/i2c_fault_guard.sv
module i2c_fault_guard #(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] ERR_CODE = 8'h00,
  parameter logic [7:0] IDLE_CODE = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       byte_active,
  input  logic       link_owned,
  input  logic       sto_set,
  input  logic       si_clear,
  output logic       sto,
  output logic       si,
  output logic [7:0] status,
  output logic       sda_release,
  output logic       scl_release,
  output logic       drop_to_unaddressed
);
  logic [SYNC_STAGES-1:0] sda_sh, scl_sh;
  logic sda_d, scl_d, fault_q, rel_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sda_sh <= '1;
      scl_sh <= '1;
      sda_d  <= 1'b1;
      scl_d  <= 1'b1;
    end else begin
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_d  <= sda_sh[SYNC_STAGES-1];
      scl_d  <= scl_sh[SYNC_STAGES-1];
    end

  wire sda_s   = sda_sh[SYNC_STAGES-1];
  wire scl_hi  = scl_sh[SYNC_STAGES-1] & scl_d;
  wire start_c = scl_hi & sda_d & ~sda_s;
  wire stop_c  = scl_hi & ~sda_d & sda_s;
  wire hit     = (start_c | stop_c) & byte_active & link_owned & ~fault_q;
  wire recover = fault_q & sto & ~si;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fault_q <= 1'b0;
      si      <= 1'b0;
      sto     <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      rel_q <= recover;
      if (hit) fault_q <= 1'b1;
      else if (recover) fault_q <= 1'b0;
      if (hit) si <= 1'b1;
      else if (si_clear) si <= 1'b0;
      if (recover) sto <= 1'b0;
      else if (sto_set) sto <= 1'b1;
    end

  assign status              = si ? ERR_CODE : IDLE_CODE;
  assign sda_release         = rel_q;
  assign scl_release         = rel_q;
  assign drop_to_unaddressed = rel_q;
endmodule

module i2c_fault_guard_chk #(
  parameter logic [7:0] ERR_CODE = 8'h00,
  parameter logic [7:0] IDLE_CODE = 8'hF8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_in,
  input logic       scl_in,
  input logic       byte_active,
  input logic       link_owned,
  input logic       sto_set,
  input logic       si_clear,
  input logic       sto,
  input logic       si,
  input logic [7:0] status,
  input logic       sda_release,
  input logic       scl_release,
  input logic       drop_to_unaddressed
);
  p_fault_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> $past(byte_active && link_owned));
  p_fault_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    si |-> status == ERR_CODE);
  p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !si |-> status == IDLE_CODE);
  p_release_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_release |-> $past(sto && !si));
  p_release_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_release |=> !sda_release);
  p_sto_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sto) |-> (sda_release && scl_release && drop_to_unaddressed));
endmodule

bind i2c_fault_guard i2c_fault_guard_chk #(.ERR_CODE(ERR_CODE), .IDLE_CODE(IDLE_CODE)) u_chk (.*);

// File: tb/i2c_fault_guard_test.sv
module i2c_fault_guard_test;
  logic clk = 0, rst_n = 0;
  logic sda_in = 1, scl_in = 1, byte_active = 0, link_owned = 0, sto_set = 0, si_clear = 0;
  logic sto, si, sda_release, scl_release, drop_to_unaddressed;
  logic [7:0] status;
  int checks = 0, errors = 0, rel_cnt = 0, drop_cnt = 0;

  i2c_fault_guard uut (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (sda_release && scl_release) rel_cnt++;
    if (drop_to_unaddressed) drop_cnt++;
  end

  function automatic bit exp_fault(bit owned, bit frame, bit cond);
    return owned & frame & cond;
  endfunction

  function automatic logic [7:0] exp_status(bit flag);
    return flag ? 8'h00 : 8'hF8;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sto();
    @(negedge clk); sto_set = 1; @(negedge clk); sto_set = 0;
  endtask

  task automatic pulse_si();
    @(negedge clk); si_clear = 1; @(negedge clk); si_clear = 0;
  endtask

  // kind: 0 start, 1 stop, 2 data toggle with SCL low
  task automatic bus_cond(int kind);
    scl_in = 0; wt(4);
    sda_in = (kind == 0) ? 1'b1 : (kind == 1) ? 1'b0 : sda_in; wt(4);
    if (kind != 2) begin
      scl_in = 1; wt(4);
      sda_in = ~sda_in; wt(4);
    end else begin
      sda_in = ~sda_in; wt(4);
      scl_in = 1; wt(4);
    end
  endtask

  task automatic recover_all(string req);
    int r0;
    r0 = rel_cnt;
    pulse_sto(); pulse_si(); wt(4);
    chk(req, rel_cnt - r0, 1);
    chk(req, sto, 0);
    chk(req, si, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0, d0;
    void'($urandom(32'h1C0DE));
    wt(3); rst_n = 1; wt(2);
    chk("R5 reset si", si, 0);
    chk("R5 reset status", status, 8'hF8);
    chk("R7 reset release", sda_release, 0);

    byte_active = 1; link_owned = 1;
    bus_cond(0);
    chk("R1 start si", si, 1);
    chk("R1 start status", status, 8'h00);
    r0 = rel_cnt; d0 = drop_cnt;
    pulse_sto(); pulse_si(); wt(4);
    chk("R7 release once", rel_cnt - r0, 1);
    chk("R7 drop once", drop_cnt - d0, 1);
    chk("R7 sto cleared", sto, 0);
    chk("R5 status after", status, 8'hF8);

    bus_cond(1);
    chk("R2 stop si", si, 1);
    chk("R2 stop status", status, 8'h00);
    r0 = rel_cnt;
    pulse_si(); wt(4);
    chk("R8 si only no release", rel_cnt - r0, 0);
    bus_cond(0);
    chk("R8 no refault", si, 0);
    chk("R5 idle code", status, 8'hF8);
    pulse_sto(); wt(4);
    chk("R7 late sto release", rel_cnt - r0, 1);
    chk("R7 sto cleared late", sto, 0);

    bus_cond(0);
    r0 = rel_cnt;
    pulse_sto(); wt(4);
    chk("R8 sto only no release", rel_cnt - r0, 0);
    chk("R8 sto held", sto, 1);
    chk("R8 si held", si, 1);
    pulse_si(); wt(4);
    chk("R7 sto-first release", rel_cnt - r0, 1);

    link_owned = 0; bus_cond(0); bus_cond(1);
    chk("R3 unowned", si, 0);
    link_owned = 1; byte_active = 0; bus_cond(0); bus_cond(1);
    chk("R4 between frames", si, 0);
    byte_active = 1; bus_cond(2); bus_cond(2);
    chk("R6 data bit", si, 0);

    byte_active = 0;
    r0 = rel_cnt;
    pulse_sto(); wt(4);
    chk("R9 sto set", sto, 1);
    pulse_si(); wt(4);
    chk("R9 sto kept", sto, 1);
    chk("R9 no release", rel_cnt - r0, 0);
    byte_active = 1; bus_cond(1);
    chk("R9 fault with sto", si, 1);
    pulse_si(); wt(4);
    chk("R9 release on clear", rel_cnt - r0, 1);
    chk("R9 sto cleared", sto, 0);

    for (int i = 0; i < 60; i++) begin
      bit own, frm;
      int kind;
      bit e;
      own = 1'($urandom_range(0, 1));
      frm = 1'($urandom_range(0, 1));
      kind = int'($urandom_range(0, 2));
      link_owned = own; byte_active = frm;
      bus_cond(kind);
      e = exp_fault(own, frm, kind != 2);
      chk(kind == 2 ? "R6 random" : (own && frm) ? (kind == 0 ? "R1 random" : "R2 random")
          : (!own ? "R3 random" : "R4 random"), si, e);
      chk("R5 random status", status, exp_status(e));
      if (e) recover_all("R7 random recover");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule